// File: doc/BRIEF.md
# Programmable Trigger State Sequencer

This block is the sequencing stage of an on-chip debug trigger. It steps through three working states (State1, State2, State3) and a terminal Final state, driven by single-cycle pulses from four comparator match channels. The comparators themselves, trace capture and breakpoint generation are handled elsewhere. Each working state has its own 4-bit select code. The code decides which match channel moves the sequencer and to which state. When several channels pulse in the same cycle, a match that leads to Final beats all others. Otherwise the lowest-numbered channel wins.

Software loads the select codes through one shared 8-bit register window. A 2-bit bank field picks the state whose code is accessed. The codes can be changed only while the sequencer is disarmed. An arm pulse starts the sequence in State1. The block reports its current state and raises a one-cycle pulse when it enters Final. It holds Final until a disarm pulse returns it to idle. There is no data stream at the boundary. Every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `trig_seq`

## Requirements
- R1: After reset, `state_o` is idle (encoding 000), `final_pulse` is low, and all three select codes read as zero.
- R2: The register window is selected by `bank_sel`: 00 selects the State1 code, 01 the State2 code and 10 the State3 code. Value 11 selects nothing: it reads zero and writes to it are dropped. A code is held in bits 3:0 of the register, and bits 7:4 always read zero.
- R3: A write with `reg_wr` high is ignored whenever the sequencer is armed, which means `state_o` is not idle (this includes Final).
- R4: State encodings are 001 for State1, 010 for State2, 011 for State3 and 100 for Final. An `arm` pulse while idle gives State1 on the next cycle. `arm` is ignored while armed, and match pulses are ignored while idle. `disarm` gives idle on the next cycle and wins over a simultaneous `arm`.
- R5: In State2, code 0000 sends any match to State1, 0001 sends any match to State3, and 0010 sends any match to Final.
- R6: In State2, code 0011 sends Match3 to State1 and code 0100 sends Match3 to State3. Under both codes, Match0 to Match2 cause no transition.
- R7: In State1, the codes act as follows:
  - 0111: Match0 goes to Final and Match1 to State3.
  - 1000: Match0 goes to State2 and Match2 to State3.
  - 1001: Match0 goes to Final and Match2 to State3.
  - 1010: Match1 goes to State2 and Match3 to State3.
  - 1011: Match1 goes to Final and Match3 to State3.
  - 1100: any of Match0 to Match2 goes to State2, and Match3 has no effect.
- R8: Codes 1101 to 1111 cause no transition, and neither does any other code not listed in R5 to R7. State3 never leaves on a match, whatever its code.
- R9: Simultaneous matches are resolved by priority. A match that targets Final wins first. Otherwise the lowest-numbered channel that causes a transition wins.
- R10: Final is held, whatever the matches, until disarm. `final_pulse` is high for exactly the first cycle in which `state_o` shows Final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm pulse, starts the sequence in State1 |
| disarm | input | 1 | Disarm pulse, returns to idle |
| bank_sel | input | 2 | Selects which state's code register is accessed |
| reg_wr | input | 1 | Write strobe for the code register window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| match | input | 4 | Comparator match pulses, bit n is channel n |
| state_o | output | 3 | Current sequencer state |
| final_pulse | output | 1 | One-cycle pulse on entering Final |

## Verification
The bench builds the block with its default parameters: four match channels, 4-bit codes, an 8-bit register window and a 2-bit bank field. At these sizes every one of the 16 codes for State1 and State2 can be paired with all 15 non-empty match patterns. That covers every listed table entry, every reserved code and every simultaneous-match priority case. The narrow bank field also puts the unused fourth bank value within reach, so the dropped writes and zero reads can be checked.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seq_state_e;

  // working states that own a code register
  localparam int NUM_TABLES = 3;

  // target of channel ch in state cur under code; ST_IDLE means no move
  function automatic seq_state_e route(seq_state_e cur, logic [3:0] code, int ch);
    seq_state_e t;
    t = ST_IDLE;
    if (cur == ST_ONE) begin
      case (code)
        4'b0111: t = (ch == 0) ? ST_FINAL : (ch == 1) ? ST_THREE : ST_IDLE;
        4'b1000: t = (ch == 0) ? ST_TWO   : (ch == 2) ? ST_THREE : ST_IDLE;
        4'b1001: t = (ch == 0) ? ST_FINAL : (ch == 2) ? ST_THREE : ST_IDLE;
        4'b1010: t = (ch == 1) ? ST_TWO   : (ch == 3) ? ST_THREE : ST_IDLE;
        4'b1011: t = (ch == 1) ? ST_FINAL : (ch == 3) ? ST_THREE : ST_IDLE;
        4'b1100: t = (ch <= 2) ? ST_TWO : ST_IDLE;
        default: t = ST_IDLE;
      endcase
    end else if (cur == ST_TWO) begin
      case (code)
        4'b0000: t = ST_ONE;
        4'b0001: t = ST_THREE;
        4'b0010: t = ST_FINAL;
        4'b0011: t = (ch == 3) ? ST_ONE : ST_IDLE;
        4'b0100: t = (ch == 3) ? ST_THREE : ST_IDLE;
        default: t = ST_IDLE;
      endcase
    end
    return t;
  endfunction

endpackage

// File: rtl/trig_seq_regs.sv
module trig_seq_regs
  import trig_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4,
  parameter int BANK_W = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  lock,
  input  logic                                  wr,
  input  logic [BANK_W-1:0]                     bank,
  input  logic [DATA_W-1:0]                     wdata,
  output logic [DATA_W-1:0]                     rdata,
  output logic [NUM_TABLES-1:0][CODE_W-1:0]     codes
);

  localparam int PAD_W = DATA_W - CODE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codes <= '0;
    end else if (wr && !lock) begin
      for (int g = 0; g < NUM_TABLES; g++) begin
        if (bank == BANK_W'(g)) codes[g] <= wdata[CODE_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NUM_TABLES; g++) begin
      if (bank == BANK_W'(g)) rdata = {{PAD_W{1'b0}}, codes[g]};
    end
  end

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(codes));

endmodule

// File: rtl/trig_seq_route.sv
module trig_seq_route
  import trig_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 4
) (
  input  seq_state_e        cur,
  input  logic [CODE_W-1:0] code,
  input  logic [NUM_CH-1:0] match,
  output seq_state_e        nxt
);

  seq_state_e tgt [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign tgt[g] = match[g] ? route(cur, code, g) : ST_IDLE;
  end

  always_comb begin
    nxt = ST_IDLE;
    // walk downward so the lowest channel is the last to claim
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (tgt[i] != ST_IDLE) nxt = tgt[i];
    end
    // a move to Final outranks every other claim
    for (int i = 0; i < NUM_CH; i++) begin
      if (tgt[i] == ST_FINAL) nxt = ST_FINAL;
    end
  end

endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       disarm,
  input  seq_state_e nxt,
  output seq_state_e state,
  output logic       final_pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      final_pulse <= 1'b0;
    end else begin
      final_pulse <= 1'b0;
      if (disarm) begin
        state <= ST_IDLE;
      end else if (state == ST_IDLE) begin
        if (arm) state <= ST_ONE;
      end else if (state != ST_FINAL && nxt != ST_IDLE) begin
        state       <= nxt;
        final_pulse <= (nxt == ST_FINAL);
      end
    end
  end

  // R4
  disarm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> state == ST_IDLE);
  // R4
  arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && arm && !disarm) |=> state == ST_ONE);
  // R8
  third_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_THREE && !disarm) |=> state == ST_THREE);
  // R10
  final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FINAL && !disarm) |=> state == ST_FINAL);
  // R10
  pulse_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_pulse |-> (state == ST_FINAL && $past(state) != ST_FINAL));

endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 4,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              disarm,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] match,
  output logic [2:0]        state_o,
  output logic              final_pulse
);

  logic [NUM_TABLES-1:0][CODE_W-1:0] codes;
  logic [CODE_W-1:0] cur_code;
  seq_state_e        state;
  seq_state_e        nxt;
  logic              armed;

  assign armed   = (state != ST_IDLE);
  assign state_o = state;

  always_comb begin
    case (state)
      ST_ONE:  cur_code = codes[0];
      ST_TWO:  cur_code = codes[1];
      default: cur_code = codes[2];
    endcase
  end

  trig_seq_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .lock(armed), .wr(reg_wr), .bank(bank_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .codes(codes)
  );

  trig_seq_route #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_route (
    .cur(state), .code(cur_code), .match(match), .nxt(nxt)
  );

  trig_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .nxt(nxt),
    .state(state), .final_pulse(final_pulse)
  );

endmodule

// File: tb/trig_seq_test.sv
module trig_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0, disarm = 1'b0, reg_wr = 1'b0;
  logic [1:0] bank_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [3:0] match = 4'd0;
  logic [2:0] state_o;
  logic       final_pulse;

  int cyc = 0, runs = 0, fails = 0;
  bit finished = 0;

  // scoreboard queues: state/pulse items and read items
  int         s_due[$];
  logic [2:0] s_st[$];
  logic       s_fp[$];
  string      s_tag[$];
  int         r_due[$];
  logic [7:0] r_val[$];
  string      r_tag[$];

  logic [2:0] mst = 3'd0;
  logic [3:0] mc [3] = '{4'd0, 4'd0, 4'd0};

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trig_seq uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .bank_sel(bank_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match(match),
    .state_o(state_o), .final_pulse(final_pulse)
  );

  function automatic logic [2:0] ref_next(logic [2:0] s, logic [3:0] c, logic [3:0] m);
    logic [2:0] n = s;
    if (s == 3'd1) begin
      case (c)
        4'd7:  if (m[0]) n = 3'd4; else if (m[1]) n = 3'd3;
        4'd8:  if (m[0]) n = 3'd2; else if (m[2]) n = 3'd3;
        4'd9:  if (m[0]) n = 3'd4; else if (m[2]) n = 3'd3;
        4'd10: if (m[1]) n = 3'd2; else if (m[3]) n = 3'd3;
        4'd11: if (m[1]) n = 3'd4; else if (m[3]) n = 3'd3;
        4'd12: if (|m[2:0]) n = 3'd2;
        default: n = s;
      endcase
    end else if (s == 3'd2) begin
      case (c)
        4'd0: if (|m) n = 3'd1;
        4'd1: if (|m) n = 3'd3;
        4'd2: if (|m) n = 3'd4;
        4'd3: if (m[3]) n = 3'd1;
        4'd4: if (m[3]) n = 3'd3;
        default: n = s;
      endcase
    end
    return n;
  endfunction

  task automatic drv(input logic a, input logic d, input logic [3:0] m,
                     input logic w, input logic [1:0] b, input logic [7:0] wd,
                     input string tag);
    logic [2:0] nx;
    @(posedge clk); #1;
    arm = a; disarm = d; match = m; reg_wr = w; bank_sel = b; reg_wdata = wd;
    if (w && mst == 3'd0 && b != 2'd3) mc[b] = wd[3:0];
    if (d) nx = 3'd0;
    else if (mst == 3'd0) nx = a ? 3'd1 : 3'd0;
    else if (mst == 3'd4) nx = 3'd4;
    else nx = ref_next(mst, (mst == 3'd3) ? mc[2] : mc[mst - 3'd1], m);
    s_due.push_back(cyc + 1); s_st.push_back(nx);
    s_fp.push_back(!d && nx == 3'd4 && mst != 3'd4); s_tag.push_back(tag);
    mst = nx;
  endtask

  task automatic idle(input string tag);
    drv(0, 0, 4'd0, 0, 2'd0, 8'd0, tag);
  endtask

  task automatic wr(input logic [1:0] b, input logic [7:0] v, input string tag);
    drv(0, 0, 4'd0, 1, b, v, tag);
  endtask

  task automatic rd(input logic [1:0] b, input string tag);
    drv(0, 0, 4'd0, 0, b, 8'd0, tag);
    r_due.push_back(cyc); r_val.push_back(b == 2'd3 ? 8'd0 : {4'd0, mc[b]});
    r_tag.push_back(tag);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    while (r_due.size() > 0 && r_due[0] <= cyc) begin
      runs++;
      if (reg_rdata !== r_val[0]) begin
        fails++;
        $display("FAIL %s: rdata got %h expected %h", r_tag[0], reg_rdata, r_val[0]);
      end
      void'(r_due.pop_front()); void'(r_val.pop_front()); void'(r_tag.pop_front());
    end
    while (s_due.size() > 0 && s_due[0] <= cyc) begin
      runs++;
      if (state_o !== s_st[0] || final_pulse !== s_fp[0]) begin
        fails++;
        $display("FAIL %s: state/pulse got %0d/%0d expected %0d/%0d",
                 s_tag[0], state_o, final_pulse, s_st[0], s_fp[0]);
      end
      void'(s_due.pop_front()); void'(s_st.pop_front());
      void'(s_fp.pop_front()); void'(s_tag.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values
    for (int b = 0; b < 4; b++) rd(2'(b), "R1 reset read");
    idle("R1 reset state");
    // R2: banking and upper bits
    wr(2'd0, 8'hF7, "R2"); wr(2'd1, 8'hA4, "R2"); wr(2'd2, 8'h3C, "R2");
    wr(2'd3, 8'hFF, "R2 bank3 write");
    for (int b = 0; b < 4; b++) rd(2'(b), "R2 bank read");
    // R4: matches ignored while idle, disarm beats arm
    drv(0, 0, 4'hF, 0, 2'd0, 8'd0, "R4 idle match");
    drv(1, 1, 4'd0, 0, 2'd0, 8'd0, "R4 disarm wins");
    // R7 R8 R9: State1 sweep
    for (int c = 0; c < 16; c++) begin
      for (int m = 1; m < 16; m++) begin
        drv(0, 1, 4'd0, 0, 2'd0, 8'd0, "R4 disarm");
        wr(2'd0, 8'(c), "R7 setup");
        drv(1, 0, 4'd0, 0, 2'd0, 8'd0, "R4 arm");
        drv(0, 0, 4'(m), 0, 2'd0, 8'd0, "R7/R8/R9 state1 step");
        idle("R10 hold");
      end
    end
    // R5 R6 R8 R9: State2 sweep
    for (int c = 0; c < 16; c++) begin
      for (int m = 1; m < 16; m++) begin
        drv(0, 1, 4'd0, 0, 2'd0, 8'd0, "R4 disarm");
        wr(2'd0, 8'd12, "R7 setup");
        wr(2'd1, 8'(c), "R5 setup");
        drv(1, 0, 4'd0, 0, 2'd0, 8'd0, "R4 arm");
        drv(0, 0, 4'b0001, 0, 2'd0, 8'd0, "R7 to state2");
        drv(0, 0, 4'(m), 0, 2'd0, 8'd0, "R5/R6/R8/R9 state2 step");
        idle("R10 hold");
      end
    end
    // R8: State3 never leaves
    foreach (mc[i]) ;
    for (int c3 = 0; c3 < 16; c3 += 5) begin
      drv(0, 1, 4'd0, 0, 2'd0, 8'd0, "R4 disarm");
      wr(2'd0, 8'd8, "R8 setup");
      wr(2'd2, 8'(c3), "R8 setup");
      drv(1, 0, 4'd0, 0, 2'd0, 8'd0, "R4 arm");
      drv(0, 0, 4'b0100, 0, 2'd0, 8'd0, "R7 to state3");
      for (int m = 1; m < 16; m++) drv(0, 0, 4'(m), 0, 2'd0, 8'd0, "R8 state3 hold");
    end
    // R3: writes blocked while armed, also in Final; arm ignored while armed
    drv(0, 1, 4'd0, 0, 2'd0, 8'd0, "R4 disarm");
    wr(2'd0, 8'd7, "R3 setup");
    wr(2'd1, 8'd2, "R3 setup");
    drv(1, 0, 4'd0, 0, 2'd0, 8'd0, "R4 arm");
    wr(2'd0, 8'd5, "R3 armed write");
    rd(2'd0, "R3 armed read");
    drv(1, 0, 4'd0, 0, 2'd0, 8'd0, "R4 arm while armed");
    drv(0, 0, 4'b0011, 0, 2'd0, 8'd0, "R9 final first");
    wr(2'd1, 8'd9, "R3 final write");
    rd(2'd1, "R3 final read");
    for (int m = 1; m < 16; m++) drv(0, 0, 4'(m), 0, 2'd0, 8'd0, "R10 final hold");
    drv(0, 1, 4'd0, 0, 2'd0, 8'd0, "R10 leave final");
    wr(2'd1, 8'd9, "R3 write after disarm");
    rd(2'd1, "R3 read after disarm");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule